// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block is the data-memory front end of a small processor core. Each access gives it an 8-bit operand taken from the instruction. The block turns that operand into a 12-bit byte address and then reads or writes a byte-wide register file behind it. The address space holds 4096 bytes, arranged as 16 pages of 256 bytes. The upper four address bits come from a bank register that software loads with a literal. A per-access window flag overrides that register: it maps the low part of page 0 and the upper part of page 15 into one flat 256-byte view.

A separate move mode supplies complete 12-bit source and destination addresses and never looks at the bank register. It copies one byte in one cycle. Only some pages hold storage: a parameter sets how many, counted upward from page 0, and page 15 is always present. A read from any other page returns zero, and a write to it is dropped. Reads are combinational from the resolved address. Writes and bank loads take effect on the rising clock edge.

Top module: `bankmem_unit`

## Requirements
- R1: With `op_move`=0 and `op_access`=0, `rd_addr` equals the bank register value in bits 11:8 and `op_operand` in bits 7:0.
- R2: With `op_move`=0 and `op_access`=1, `rd_addr` is `{4'h0, op_operand}` when `op_operand` < 0x60, and `{4'hF, op_operand}` otherwise, whatever value the bank register holds.
- R3: `bank_ld`=1 loads `bank_lit[3:0]` into the bank register at the clock edge. `bank_sel[7:4]` always reads 0. Without `bank_ld` the register keeps its value. A synchronous reset clears it to 0.
- R4: With `op_move`=1, `rd_addr` equals `mv_src` and `rd_data` is the byte stored there. At the next edge that byte is written to `mv_dst`. The bank register and `op_access` have no effect on the move.
- R5: A page is implemented when its number is below `LOW_BANKS` (default 2) or equals 15. Any resolved address in another page reads as 0x00.
- R6: A write (`wr_en`=1, `op_move`=0) to an address in an unimplemented page changes no stored byte, including bytes that have the same low 8 address bits in the implemented pages.
- R7: A write lands at the rising edge. In the cycle of the write, `rd_data` still shows the old byte at that address. From the next cycle on it shows the new byte.
- R8: A move to an unimplemented destination stores nothing. A move from an unimplemented source writes 0x00 to an implemented destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the bank register |
| op_move | input | 1 | 1 selects a full-address move, 0 selects an operand access |
| op_access | input | 1 | Window flag for operand accesses |
| op_operand | input | 8 | Low-order operand from the instruction |
| mv_src | input | 12 | Move source address |
| mv_dst | input | 12 | Move destination address |
| wr_en | input | 1 | Write enable for operand accesses |
| wr_data | input | 8 | Byte to write on an operand access |
| bank_ld | input | 1 | Load the bank register from the literal |
| bank_lit | input | 8 | Literal for the bank register |
| rd_addr | output | 12 | Resolved read address |
| rd_data | output | 8 | Byte at the resolved address, 0 when unimplemented |
| bank_sel | output | 8 | Bank register as seen by software, upper nibble zero |

## Verification
The assertions check address formation on every cycle: the banked concatenation, both halves of the window map, and the source address of a move. They also check the bank register's load, hold and zero upper nibble, and that unimplemented pages read zero. What the storage holds after a write or a move cannot be seen on any single cycle. The bench's reference model shows it, in these cases: dropped writes to gap pages and the absence of aliasing into implemented pages, old-before-new data in a write cycle, moves under a nonzero bank value, and moves into or out of gap pages.

// File: rtl/bankmem_pkg.sv
package bankmem_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 8;
    localparam int PAGE_W   = 4;
    localparam int OFS_W    = 8;
    localparam logic [PAGE_W-1:0] SFR_PAGE = 4'hF;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [OFS_W-1:0]  ofs_t;

    // one access request as presented by the decoder
    typedef struct packed {
        logic  move;
        logic  access;
        ofs_t  operand;
        addr_t src;
        addr_t dst;
    } op_req_t;

    // where an address lands in physical storage
    typedef struct packed {
        logic  hit;
        page_t slot;
    } loc_t;

    // flat window: low operands go to page 0, the rest to the SFR page
    function automatic addr_t window_map(ofs_t opd, ofs_t split);
        return (opd < split) ? {4'h0, opd} : {SFR_PAGE, opd};
    endfunction

    // low pages occupy slots 0..low_lim-1, the SFR page takes slot low_lim
    function automatic loc_t locate(addr_t a, page_t low_lim);
        loc_t  l;
        page_t pg;
        pg     = a[ADDR_W-1 -: PAGE_W];
        l.hit  = (pg < low_lim) || (pg == SFR_PAGE);
        l.slot = (pg == SFR_PAGE) ? low_lim : pg;
        return l;
    endfunction

endpackage

// File: rtl/bankmem_bsr.sv
module bankmem_bsr
    import bankmem_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  data_t lit,
    output page_t page
);
    always_ff @(posedge clk) begin
        if (rst) begin
            page <= '0;
        end else if (load) begin
            page <= lit[PAGE_W-1:0];
        end
    end
endmodule

// File: rtl/bankmem_resolve.sv
module bankmem_resolve
    import bankmem_pkg::*;
#(
    parameter int   LOW_BANKS    = 2,
    parameter ofs_t ACCESS_SPLIT = 8'h60
) (
    input  op_req_t req,
    input  page_t   page,
    output addr_t   rd_addr,
    output loc_t    rd_loc,
    output addr_t   wr_addr,
    output loc_t    wr_loc
);
    localparam page_t LOW_LIM = page_t'(LOW_BANKS);

    addr_t opd_addr;

    always_comb begin
        if (req.access) begin
            opd_addr = window_map(req.operand, ACCESS_SPLIT);
        end else begin
            opd_addr = {page, req.operand};
        end
        rd_addr = req.move ? req.src : opd_addr;
        wr_addr = req.move ? req.dst : opd_addr;
        rd_loc  = locate(rd_addr, LOW_LIM);
        wr_loc  = locate(wr_addr, LOW_LIM);
    end
endmodule

// File: rtl/bankmem_bank.sv
module bankmem_bank
    import bankmem_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  ofs_t  waddr,
    input  data_t wdata,
    input  ofs_t  raddr,
    output data_t rdata
);
    localparam int DEPTH = 1 << OFS_W;

    data_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/bankmem_unit.sv
module bankmem_unit
    import bankmem_pkg::*;
#(
    parameter int          LOW_BANKS    = 2,
    parameter logic [7:0]  ACCESS_SPLIT = 8'h60
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        op_move,
    input  logic        op_access,
    input  logic [7:0]  op_operand,
    input  logic [11:0] mv_src,
    input  logic [11:0] mv_dst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        bank_ld,
    input  logic [7:0]  bank_lit,
    output logic [11:0] rd_addr,
    output logic [7:0]  rd_data,
    output logic [7:0]  bank_sel
);
    localparam int NSLOT   = LOW_BANKS + 1;
    localparam int SLOT_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int NSLOT_P = 1 << SLOT_W;

    op_req_t req;
    page_t   page;
    addr_t   wr_addr;
    loc_t    rd_loc;
    loc_t    wr_loc;
    logic    wr_fire;
    data_t   wr_val;
    data_t   slot_rd [NSLOT_P];

    assign req = '{move: op_move, access: op_access, operand: op_operand,
                   src: mv_src, dst: mv_dst};

    bankmem_bsr u_bsr (
        .clk  (clk),
        .rst  (rst),
        .load (bank_ld),
        .lit  (bank_lit),
        .page (page)
    );

    bankmem_resolve #(
        .LOW_BANKS    (LOW_BANKS),
        .ACCESS_SPLIT (ACCESS_SPLIT)
    ) u_resolve (
        .req     (req),
        .page    (page),
        .rd_addr (rd_addr),
        .rd_loc  (rd_loc),
        .wr_addr (wr_addr),
        .wr_loc  (wr_loc)
    );

    // a move always writes; an operand access writes on request
    assign wr_fire = (op_move | wr_en) & wr_loc.hit;
    assign wr_val  = op_move ? rd_data : wr_data;

    for (genvar s = 0; s < NSLOT_P; s++) begin : g_slot
        if (s < NSLOT) begin : g_store
            logic we_s;
            assign we_s = wr_fire && (wr_loc.slot == page_t'(s));
            bankmem_bank u_bank (
                .clk   (clk),
                .we    (we_s),
                .waddr (wr_addr[OFS_W-1:0]),
                .wdata (wr_val),
                .raddr (rd_addr[OFS_W-1:0]),
                .rdata (slot_rd[s])
            );
        end else begin : g_gap
            assign slot_rd[s] = '0;
        end
    end

    assign rd_data  = rd_loc.hit ? slot_rd[rd_loc.slot[SLOT_W-1:0]] : '0;
    assign bank_sel = {4'h0, page};
endmodule

// File: rtl/bankmem_checker.sv
module bankmem_checker #(
    parameter int         LOW_BANKS    = 2,
    parameter logic [7:0] ACCESS_SPLIT = 8'h60
) (
    input logic        clk,
    input logic        rst,
    input logic        op_move,
    input logic        op_access,
    input logic [7:0]  op_operand,
    input logic [11:0] mv_src,
    input logic        bank_ld,
    input logic [7:0]  bank_lit,
    input logic [11:0] rd_addr,
    input logic [7:0]  rd_data,
    input logic [7:0]  bank_sel
);
    localparam logic [3:0] LOW_LIM = 4'(LOW_BANKS);

    logic gap_page;
    assign gap_page = (rd_addr[11:8] >= LOW_LIM) && (rd_addr[11:8] != 4'hF);

    a_r1_banked_addr: assert property (@(posedge clk) disable iff (rst)
        (!op_move && !op_access) |-> (rd_addr == {bank_sel[3:0], op_operand}));

    a_r2_window_low: assert property (@(posedge clk) disable iff (rst)
        (!op_move && op_access && op_operand < ACCESS_SPLIT)
            |-> (rd_addr[11:8] == 4'h0 && rd_addr[7:0] == op_operand));

    a_r2_window_high: assert property (@(posedge clk) disable iff (rst)
        (!op_move && op_access && op_operand >= ACCESS_SPLIT)
            |-> (rd_addr[11:8] == 4'hF && rd_addr[7:0] == op_operand));

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bank_sel[7:4] == 4'h0);

    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        bank_ld |=> (bank_sel[3:0] == $past(bank_lit[3:0])));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !bank_ld |=> $stable(bank_sel));

    a_r4_move_src: assert property (@(posedge clk) disable iff (rst)
        op_move |-> (rd_addr == mv_src));

    a_r5_gap_zero: assert property (@(posedge clk) disable iff (rst)
        gap_page |-> (rd_data == 8'h00));
endmodule

bind bankmem_unit bankmem_checker #(
    .LOW_BANKS    (LOW_BANKS),
    .ACCESS_SPLIT (ACCESS_SPLIT)
) u_checker (
    .clk        (clk),
    .rst        (rst),
    .op_move    (op_move),
    .op_access  (op_access),
    .op_operand (op_operand),
    .mv_src     (mv_src),
    .bank_ld    (bank_ld),
    .bank_lit   (bank_lit),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .bank_sel   (bank_sel)
);

// File: tb/tb_bankmem_unit.sv
module tb_bankmem_unit;
    localparam int LOW_BANKS = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_move, op_access, wr_en, bank_ld;
    logic [7:0]  op_operand, wr_data, bank_lit;
    logic [11:0] mv_src, mv_dst;
    logic [11:0] rd_addr;
    logic [7:0]  rd_data, bank_sel;

    always #4 clk = ~clk;

    bankmem_unit #(.LOW_BANKS(LOW_BANKS)) dut (
        .clk(clk), .rst(rst), .op_move(op_move), .op_access(op_access),
        .op_operand(op_operand), .mv_src(mv_src), .mv_dst(mv_dst),
        .wr_en(wr_en), .wr_data(wr_data), .bank_ld(bank_ld), .bank_lit(bank_lit),
        .rd_addr(rd_addr), .rd_data(rd_data), .bank_sel(bank_sel)
    );

    int checks = 0;
    int errors = 0;

    string       q_req  [$];
    logic [11:0] q_addr [$];
    logic [7:0]  q_data [$];
    logic [7:0]  q_bsr  [$];

    logic [7:0] model_mem [4096];
    logic [3:0] model_bsr;

    function automatic bit implemented(logic [11:0] a);
        return (a[11:8] < 4'(LOW_BANKS)) || (a[11:8] == 4'hF);
    endfunction

    task automatic check(string req, string what, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus, push expectation, advance the model
    task automatic step(input logic mv, input logic acc, input logic [7:0] opd,
                        input logic [11:0] src, input logic [11:0] dst,
                        input logic we, input logic [7:0] wd,
                        input logic bl, input logic [7:0] blit, input string req);
        logic [11:0] ea;
        logic [7:0]  ed;
        @(negedge clk);
        op_move = mv; op_access = acc; op_operand = opd; mv_src = src; mv_dst = dst;
        wr_en = we; wr_data = wd; bank_ld = bl; bank_lit = blit;
        if (mv)       ea = src;
        else if (acc) ea = (opd < 8'h60) ? {4'h0, opd} : {4'hF, opd};
        else          ea = {model_bsr, opd};
        ed = implemented(ea) ? model_mem[ea] : 8'h00;
        q_req.push_back(req); q_addr.push_back(ea);
        q_data.push_back(ed); q_bsr.push_back({4'h0, model_bsr});
        if (mv) begin
            if (implemented(dst)) model_mem[dst] = ed;
        end else if (we && implemented(ea)) begin
            model_mem[ea] = wd;
        end
        if (bl) model_bsr = blit[3:0];
    endtask

    task automatic bank(input logic [7:0] lit, input string req);
        step(1'b0, 1'b0, 8'h00, 12'h0, 12'h0, 1'b0, 8'h00, 1'b1, lit, req);
    endtask
    task automatic rw(input logic acc, input logic [7:0] opd, input logic we,
                      input logic [7:0] wd, input string req);
        step(1'b0, acc, opd, 12'h0, 12'h0, we, wd, 1'b0, 8'h00, req);
    endtask
    task automatic mv(input logic [11:0] src, input logic [11:0] dst, input string req);
        step(1'b1, 1'b0, 8'h00, src, dst, 1'b0, 8'h00, 1'b0, 8'h00, req);
    endtask

    // monitor: sample 3 ns after the falling edge, before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (q_addr.size() > 0) begin
                string       r;
                logic [11:0] ea;
                logic [7:0]  ed, eb;
                r = q_req.pop_front(); ea = q_addr.pop_front();
                ed = q_data.pop_front(); eb = q_bsr.pop_front();
                check(r, "rd_addr", rd_addr, ea);
                check(r, "rd_data", {4'h0, rd_data}, {4'h0, ed});
                check(r, "bank_sel", {4'h0, bank_sel}, {4'h0, eb});
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1; op_move = 0; op_access = 0; op_operand = 0; mv_src = 0; mv_dst = 0;
        wr_en = 0; wr_data = 0; bank_ld = 0; bank_lit = 0;
        model_bsr = 4'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R3: reset value of the bank register
        rw(1'b0, 8'h00, 1'b0, 8'h00, "R3_reset");

        // fill every implemented page through banked writes (R1)
        for (int p = 0; p < 16; p++) begin
            if (p < LOW_BANKS || p == 15) begin
                bank(8'(p), "R3_fill");
                for (int o = 0; o < 256; o++)
                    rw(1'b0, 8'(o), 1'b1, 8'(p * 37 + o * 5 + 1), "R1_fill");
            end
        end
        bank(8'h01, "R3");
        for (int o = 0; o < 256; o += 17) rw(1'b0, 8'(o), 1'b0, 8'h00, "R1_read_bank1");

        // R3: upper literal bits dropped
        bank(8'hA5, "R3_upper");
        rw(1'b0, 8'h10, 1'b0, 8'h00, "R3_upper_readback");

        // R2: window with nonzero bank register at both sides of the split
        rw(1'b1, 8'h00, 1'b0, 8'h00, "R2_low_edge");
        rw(1'b1, 8'h5F, 1'b0, 8'h00, "R2_split_below");
        rw(1'b1, 8'h60, 1'b0, 8'h00, "R2_split_at");
        rw(1'b1, 8'hFF, 1'b0, 8'h00, "R2_high_edge");
        rw(1'b1, 8'h30, 1'b1, 8'h99, "R2_window_write");
        rw(1'b1, 8'h30, 1'b0, 8'h00, "R2_window_readback");

        // R5/R6: page 5 reads zero, writes there alias nowhere
        rw(1'b0, 8'h44, 1'b1, 8'hEE, "R6_gap_write");
        rw(1'b0, 8'h44, 1'b0, 8'h00, "R5_gap_read");
        bank(8'h00, "R3");
        rw(1'b0, 8'h44, 1'b0, 8'h00, "R6_no_alias_page0");
        bank(8'h01, "R3");
        rw(1'b0, 8'h44, 1'b0, 8'h00, "R6_no_alias_page1");
        bank(8'h0E, "R3");
        rw(1'b0, 8'hC3, 1'b0, 8'h00, "R5_gap_page14");

        // R7: old data in the write cycle, new data after
        bank(8'h01, "R3");
        rw(1'b0, 8'h20, 1'b1, 8'h3C, "R7_write_cycle_old");
        rw(1'b0, 8'h20, 1'b0, 8'h00, "R7_next_cycle_new");

        // R4/R8: moves under a nonzero bank register
        bank(8'h07, "R3");
        mv(12'h120, 12'h0AB, "R4_move");
        mv(12'h0AB, 12'hF01, "R4_move_chain");
        mv(12'hF01, 12'hF01, "R4_move_self");
        mv(12'h015, 12'h512, "R8_gap_dst");
        mv(12'h512, 12'h016, "R8_gap_src");
        mv(12'h016, 12'h0F0, "R8_zero_landed");
        step(1'b1, 1'b1, 8'hFF, 12'h0F0, 12'h100, 1'b1, 8'h77, 1'b0, 8'h00, "R4_access_ignored");
        mv(12'h100, 12'h101, "R4_readback");

        // R3: synchronous reset mid-run clears the bank register only
        @(negedge clk);
        op_move = 0; wr_en = 0; bank_ld = 0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_bsr = 4'h0;
        rw(1'b0, 8'h20, 1'b0, 8'h00, "R3_reset_again");

        // mixed traffic over all modes
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[1:0])
                2'd0: bank(lfsr[15:8], "R3_mix");
                2'd1: mv({lfsr[11:8], lfsr[7:0]}, {lfsr[15:12], lfsr[9:2]}, "R4_mix");
                default: rw(lfsr[2], lfsr[15:8], lfsr[3], lfsr[11:4], "R1_R2_mix");
            endcase
        end

        wait (q_addr.size() == 0);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule